// File: doc/BRIEF.md
# Extension Handle Dispatch Unit

This unit sits behind the instruction decoder and services three kinds of request: opening a handle to an attached device interface, closing such a handle, and issuing one of eight generic control opcodes through an open handle. Each request carries an rs1 operand, a data operand and the address-space ID of the running context. Opening looks up a 20-bit interface identifier among the attached devices. It then reserves a slot in an internal handle table, which records the device and the owning address space. It asks the device for a cookie and returns the handle value together with that cookie.

A control request names its handle in rs1. The handle index occupies a fixed field starting at bit 12, and the twelve low bits carry extra operand bits that go to the device on their own wires. The unit checks that the handle is open and owned by the caller. It checks the device's per-opcode support mask and only then forwards the request over a valid/ready channel. It holds the instruction until the device answers. A request naming a handle that belongs to another address space fails exactly as a request naming a closed handle does, so ownership is never disclosed.

Top module: `ovl_dispatch`

## Requirements
- R1: An open request (req_op = 0) whose identifier rs1[19:0] matches no device's identifier fails with exception code 1 (no such interface). The response arrives the cycle after acceptance, and no device request is issued.
- R2: A successful open uses the lowest-numbered free table slot and the lowest-numbered device with a matching identifier. It sends that device a request of kind 0 (init) carrying req_data. It responds with code 0, rsp_value = slot index << 12, and rsp_cookie = the device's response data.
- R3: An open with a known identifier while all 16 slots are in use fails with code 3 (resources exhausted). An unknown identifier still reports code 1 in that state.
- R4: A control request (req_op = 2) on an open handle owned by req_asid sends a request of kind 1 to the handle's device. The request carries fn = req_fn, handle = rs1[15:12], extra = rs1[11:0] and data = req_data. The response is code 0 with rsp_value = the device's data.
- R5: A control or close request whose handle slot is not open, or whose rs1 has any bit set above bit 15, fails with code 1 and forwards nothing.
- R6: A handle open under a different address space gives the same response as R5: code 1, with rsp_value and rsp_cookie both 0.
- R7: A control request whose opcode bit in the device's 8-bit support mask is clear fails with code 2 (no such instruction) and forwards nothing. Opcode value 3 also returns code 2.
- R8: A close request (req_op = 1) that passes the R5/R6 checks sends a request of kind 2 (shutdown) and returns code 0 with the device's data. It then frees the slot, so later control requests on it fail and the next open reuses it.
- R9: At most one device request is outstanding. req_ready stays low from acceptance until the response, and dev_req_valid and its payload hold steady until dev_req_ready.
- R10: After reset the table is empty, req_ready is high, and rsp_valid and every dev_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Decoded request present |
| req_ready | output | 1 | Unit idle and accepting |
| req_op | input | 2 | 0 open, 1 close, 2 control |
| req_fn | input | 3 | Control opcode number 0..7 |
| req_rs1 | input | 32 | Identifier (open) or handle plus extra bits |
| req_data | input | 32 | Data operand |
| req_asid | input | 8 | Current address-space ID |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_exc | output | 2 | 0 ok, 1 no interface, 2 no instruction, 3 exhausted |
| rsp_value | output | 32 | Handle value (open) or device result |
| rsp_cookie | output | 32 | Device cookie on open, else 0 |
| dev_if_ids | input | 80 | Four 20-bit interface identifiers, device 0 lowest |
| dev_fn_masks | input | 32 | Four 8-bit opcode support masks |
| dev_req_valid | output | 4 | Per-device request valid |
| dev_req_ready | input | 4 | Per-device request ready |
| dev_req_kind | output | 2 | 0 init, 1 control, 2 shutdown |
| dev_req_fn | output | 3 | Control opcode number |
| dev_req_extra | output | 12 | Low rs1 bits |
| dev_req_handle | output | 4 | Table slot index |
| dev_req_data | output | 32 | Data operand |
| dev_rsp_valid | input | 4 | Per-device response valid |
| dev_rsp_data | input | 128 | Four 32-bit device results |

## Verification
The devices are configured with two identical identifiers, a full support mask, a sparse mask and a single-opcode mask. This separates lowest-device priority from mask decoding. Handles are exercised through open, use, close and reopen. Each one is probed from its owner, from a foreign address space, as a closed slot and with stray high rs1 bits, which separates the ownership check from the validity check. The table is then filled to its last slot to separate the exhausted case from the unknown-identifier case. A device model that withholds ready for a cycle and answers later shows that requests are held and that only one is issued per instruction.

// File: rtl/ovl_pkg.sv
// Shared encodings for the extension handle dispatch unit.
package ovl_pkg;
    typedef enum logic [1:0] {OP_OPEN = 2'd0, OP_CLOSE = 2'd1, OP_CTL = 2'd2, OP_RSVD = 2'd3} op_e;
    typedef enum logic [1:0] {EXC_NONE = 2'd0, EXC_NO_IFACE = 2'd1, EXC_NO_INSTR = 2'd2, EXC_EXHAUSTED = 2'd3} exc_e;
    typedef enum logic [1:0] {DK_INIT = 2'd0, DK_CTL = 2'd1, DK_SHUT = 2'd2, DK_RSVD = 2'd3} dkind_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_SEND = 2'd1, ST_WAIT = 2'd2} st_e;
endpackage

// File: rtl/ovl_iface_match.sv
// Finds the lowest-numbered device whose interface identifier equals the
// requested one. Assumes identifiers are packed device 0 in the low bits.
module ovl_iface_match #(
    parameter int N_DEV  = 4,
    parameter int IFID_W = 20,
    parameter int DEV_W  = 2
) (
    input  logic [IFID_W-1:0]       id,
    input  logic [N_DEV*IFID_W-1:0] ids_flat,
    output logic                    hit,
    output logic [DEV_W-1:0]        dev
);
    logic [N_DEV-1:0] eq;

    // One comparator per attached device.
    for (genvar g = 0; g < N_DEV; g++) begin : g_cmp
        assign eq[g] = (ids_flat[g*IFID_W +: IFID_W] == id);
    end

    // Priority pick, lowest index wins.
    always_comb begin
        hit = 1'b0;
        dev = '0;
        for (int i = N_DEV - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit = 1'b1;
                dev = DEV_W'(i);
            end
        end
    end
endmodule

// File: rtl/ovl_handle_table.sv
// Open-handle table: valid bit, device index and owner address space per slot.
// Provides an ownership lookup, a lowest-free-slot search and set/clear ports.
// Assumes set and clear never target the same slot in one cycle.
module ovl_handle_table #(
    parameter int N_HANDLE = 16,
    parameter int ASID_W   = 8,
    parameter int DEV_W    = 2,
    parameter int HIDX_W   = $clog2(N_HANDLE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIDX_W-1:0] lk_idx,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [DEV_W-1:0]  lk_dev,
    output logic              free_any,
    output logic [HIDX_W-1:0] free_idx,
    input  logic              set_en,
    input  logic [HIDX_W-1:0] set_idx,
    input  logic [DEV_W-1:0]  set_dev,
    input  logic [ASID_W-1:0] set_asid,
    input  logic              clr_en,
    input  logic [HIDX_W-1:0] clr_idx
);
    logic [N_HANDLE-1:0] vld_q;
    logic [DEV_W-1:0]    dev_q  [N_HANDLE];
    logic [ASID_W-1:0]   asid_q [N_HANDLE];

    // Valid bits: set on a completed open, cleared on a completed close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (set_en) vld_q[set_idx] <= 1'b1;
            if (clr_en) vld_q[clr_idx] <= 1'b0;
        end
    end

    // Slot payload, meaningful only while the valid bit is set.
    always_ff @(posedge clk) begin
        if (set_en) begin
            dev_q[set_idx]  <= set_dev;
            asid_q[set_idx] <= set_asid;
        end
    end

    // Ownership lookup: open and owned by the caller.
    assign lk_hit = vld_q[lk_idx] && (asid_q[lk_idx] == lk_asid);
    assign lk_dev = dev_q[lk_idx];

    // Lowest free slot search.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N_HANDLE - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_any = 1'b1;
                free_idx = HIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ovl_dispatch.sv
// Top of the extension handle dispatch unit. Accepts one decoded open,
// close or control request at a time, checks it against the handle table
// and the device support masks, and either answers with an exception the
// next cycle or runs one valid/ready exchange with the target device.
// Assumes a device raises dev_rsp_valid only after accepting a request.
module ovl_dispatch
    import ovl_pkg::*;
#(
    parameter int N_DEV    = 4,
    parameter int N_HANDLE = 16,
    parameter int ASID_W   = 8,
    parameter int XLEN     = 32,
    parameter int IFID_W   = 20,
    parameter int EXTRA_W  = 12,
    parameter int N_CTL    = 8,
    parameter int FN_W     = $clog2(N_CTL),
    parameter int DEV_W    = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    parameter int HIDX_W   = $clog2(N_HANDLE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_op,
    input  logic [FN_W-1:0]         req_fn,
    input  logic [XLEN-1:0]         req_rs1,
    input  logic [XLEN-1:0]         req_data,
    input  logic [ASID_W-1:0]       req_asid,
    output logic                    rsp_valid,
    output logic [1:0]              rsp_exc,
    output logic [XLEN-1:0]         rsp_value,
    output logic [XLEN-1:0]         rsp_cookie,
    input  logic [N_DEV*IFID_W-1:0] dev_if_ids,
    input  logic [N_DEV*N_CTL-1:0]  dev_fn_masks,
    output logic [N_DEV-1:0]        dev_req_valid,
    input  logic [N_DEV-1:0]        dev_req_ready,
    output logic [1:0]              dev_req_kind,
    output logic [FN_W-1:0]         dev_req_fn,
    output logic [EXTRA_W-1:0]      dev_req_extra,
    output logic [HIDX_W-1:0]       dev_req_handle,
    output logic [XLEN-1:0]         dev_req_data,
    input  logic [N_DEV-1:0]        dev_rsp_valid,
    input  logic [N_DEV*XLEN-1:0]   dev_rsp_data
);
    localparam int HTOP = EXTRA_W + HIDX_W;

    st_e               state_q;
    logic [DEV_W-1:0]  cur_dev_q;
    dkind_e            cur_kind_q;
    logic [HIDX_W-1:0] cur_hidx_q;
    logic [FN_W-1:0]   cur_fn_q;
    logic [EXTRA_W-1:0] cur_extra_q;
    logic [XLEN-1:0]   cur_data_q;
    logic [ASID_W-1:0] cur_asid_q;
    logic              rsp_valid_q;
    exc_e              rsp_exc_q;
    logic [XLEN-1:0]   rsp_value_q;
    logic [XLEN-1:0]   rsp_cookie_q;

    logic              id_hit;
    logic [DEV_W-1:0]  id_dev;
    logic [HIDX_W-1:0] hsel;
    logic              high_clear;
    logic              lk_hit;
    logic [DEV_W-1:0]  lk_dev;
    logic              free_any;
    logic [HIDX_W-1:0] free_idx;
    logic [N_CTL-1:0]  sel_mask;
    op_e               op;
    exc_e              dec_exc;
    logic [DEV_W-1:0]  dec_dev;
    dkind_e            dec_kind;
    logic [HIDX_W-1:0] dec_hidx;
    logic              accept;
    logic              in_wait;
    logic              dev_done;
    logic [XLEN-1:0]   dev_result;
    logic              tbl_set;
    logic              tbl_clr;

    assign op         = op_e'(req_op);
    assign hsel       = req_rs1[EXTRA_W +: HIDX_W];
    assign high_clear = ((req_rs1 >> HTOP) == '0);
    assign sel_mask   = dev_fn_masks[lk_dev*N_CTL +: N_CTL];
    assign accept     = req_valid && (state_q == ST_IDLE);
    assign in_wait    = (state_q == ST_WAIT);
    assign dev_done   = in_wait && dev_rsp_valid[cur_dev_q];
    assign dev_result = dev_rsp_data[cur_dev_q*XLEN +: XLEN];
    assign tbl_set    = dev_done && (cur_kind_q == DK_INIT);
    assign tbl_clr    = dev_done && (cur_kind_q == DK_SHUT);

    ovl_iface_match #(
        .N_DEV (N_DEV),
        .IFID_W(IFID_W),
        .DEV_W (DEV_W)
    ) u_match (
        .id      (req_rs1[IFID_W-1:0]),
        .ids_flat(dev_if_ids),
        .hit     (id_hit),
        .dev     (id_dev)
    );

    ovl_handle_table #(
        .N_HANDLE(N_HANDLE),
        .ASID_W  (ASID_W),
        .DEV_W   (DEV_W),
        .HIDX_W  (HIDX_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_idx  (hsel),
        .lk_asid (req_asid),
        .lk_hit  (lk_hit),
        .lk_dev  (lk_dev),
        .free_any(free_any),
        .free_idx(free_idx),
        .set_en  (tbl_set),
        .set_idx (cur_hidx_q),
        .set_dev (cur_dev_q),
        .set_asid(cur_asid_q),
        .clr_en  (tbl_clr),
        .clr_idx (cur_hidx_q)
    );

    // Request decode: pick the exception or the device, kind and slot.
    always_comb begin
        dec_exc  = EXC_NONE;
        dec_dev  = lk_dev;
        dec_kind = DK_CTL;
        dec_hidx = hsel;
        unique case (op)
            OP_OPEN: begin
                dec_dev  = id_dev;
                dec_kind = DK_INIT;
                dec_hidx = free_idx;
                if (!id_hit)        dec_exc = EXC_NO_IFACE;
                else if (!free_any) dec_exc = EXC_EXHAUSTED;
            end
            OP_CLOSE: begin
                dec_kind = DK_SHUT;
                if (!(high_clear && lk_hit)) dec_exc = EXC_NO_IFACE;
            end
            OP_CTL: begin
                if (!(high_clear && lk_hit)) dec_exc = EXC_NO_IFACE;
                else if (!sel_mask[req_fn])  dec_exc = EXC_NO_INSTR;
            end
            default: dec_exc = EXC_NO_INSTR;
        endcase
    end

    // Sequencer: idle, present request to device, await device answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            rsp_valid_q  <= 1'b0;
            rsp_exc_q    <= EXC_NONE;
            rsp_value_q  <= '0;
            rsp_cookie_q <= '0;
            cur_dev_q    <= '0;
            cur_kind_q   <= DK_INIT;
            cur_hidx_q   <= '0;
            cur_fn_q     <= '0;
            cur_extra_q  <= '0;
            cur_data_q   <= '0;
            cur_asid_q   <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (dec_exc != EXC_NONE) begin
                            rsp_valid_q  <= 1'b1;
                            rsp_exc_q    <= dec_exc;
                            rsp_value_q  <= '0;
                            rsp_cookie_q <= '0;
                        end else begin
                            state_q     <= ST_SEND;
                            cur_dev_q   <= dec_dev;
                            cur_kind_q  <= dec_kind;
                            cur_hidx_q  <= dec_hidx;
                            cur_fn_q    <= (op == OP_CTL) ? req_fn : '0;
                            cur_extra_q <= (op == OP_OPEN) ? '0 : req_rs1[EXTRA_W-1:0];
                            cur_data_q  <= req_data;
                            cur_asid_q  <= req_asid;
                        end
                    end
                end
                ST_SEND: begin
                    if (dev_req_ready[cur_dev_q]) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (dev_done) begin
                        state_q     <= ST_IDLE;
                        rsp_valid_q <= 1'b1;
                        rsp_exc_q   <= EXC_NONE;
                        if (cur_kind_q == DK_INIT) begin
                            rsp_value_q  <= XLEN'(cur_hidx_q) << EXTRA_W;
                            rsp_cookie_q <= dev_result;
                        end else begin
                            rsp_value_q  <= dev_result;
                            rsp_cookie_q <= '0;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Per-device request valid, only the selected device while presenting.
    for (genvar g = 0; g < N_DEV; g++) begin : g_dvld
        assign dev_req_valid[g] = (state_q == ST_SEND) && (cur_dev_q == DEV_W'(g));
    end

    assign req_ready      = (state_q == ST_IDLE);
    assign dev_req_kind   = cur_kind_q;
    assign dev_req_fn     = cur_fn_q;
    assign dev_req_extra  = cur_extra_q;
    assign dev_req_handle = cur_hidx_q;
    assign dev_req_data   = cur_data_q;
    assign rsp_valid      = rsp_valid_q;
    assign rsp_exc        = rsp_exc_q;
    assign rsp_value      = rsp_value_q;
    assign rsp_cookie     = rsp_cookie_q;
endmodule

// File: rtl/ovl_dispatch_chk.sv
// Protocol checker for ovl_dispatch, attached by bind below.
module ovl_dispatch_chk #(
    parameter int N_DEV   = 4,
    parameter int XLEN    = 32,
    parameter int EXTRA_W = 12,
    parameter int FN_W    = 3,
    parameter int HIDX_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [N_DEV-1:0]   dev_req_valid,
    input logic [N_DEV-1:0]   dev_req_ready,
    input logic [1:0]         dev_req_kind,
    input logic [FN_W-1:0]    dev_req_fn,
    input logic [EXTRA_W-1:0] dev_req_extra,
    input logic [HIDX_W-1:0]  dev_req_handle,
    input logic [XLEN-1:0]    dev_req_data,
    input logic               rsp_valid,
    input logic [1:0]         rsp_exc,
    input logic [XLEN-1:0]    rsp_value,
    input logic [XLEN-1:0]    rsp_cookie,
    input logic               in_wait
);
    // R9: never more than one device addressed.
    a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_req_valid));

    // R9: no new instruction while a device exchange is in flight.
    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dev_req_valid) || in_wait) |-> !req_ready);

    // R9: a stalled request keeps its target and payload.
    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dev_req_valid & ~dev_req_ready)) |=>
        ($stable(dev_req_valid) && $stable(dev_req_kind) && $stable(dev_req_fn)
         && $stable(dev_req_extra) && $stable(dev_req_handle) && $stable(dev_req_data)));

    // R6: an exception response carries no data that could reveal a handle.
    a_r6_no_leak: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc != 2'd0) |-> (rsp_value == '0 && rsp_cookie == '0));

    // R1: an accepted request either answers at once or starts a device request.
    a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid != (|dev_req_valid)));

    // R8: only init, control or shutdown are ever sent.
    a_r8_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_req_valid) |-> (dev_req_kind != 2'd3));
endmodule

bind ovl_dispatch ovl_dispatch_chk #(
    .N_DEV  (N_DEV),
    .XLEN   (XLEN),
    .EXTRA_W(EXTRA_W),
    .FN_W   (FN_W),
    .HIDX_W (HIDX_W)
) u_chk (.*);

// File: tb/ovl_dispatch_bench.sv
`timescale 1ns/1ps
module ovl_dispatch_bench;
    localparam int NDEV = 4;
    localparam logic [1:0] OPN = 2'd0, CLS = 2'd1, CTL = 2'd2;
    localparam logic [1:0] E_OK = 2'd0, E_NIF = 2'd1, E_NIN = 2'd2, E_EXH = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0]  req_op = '0;
    logic [2:0]  req_fn = '0;
    logic [31:0] req_rs1 = '0;
    logic [31:0] req_data = '0;
    logic [7:0]  req_asid = '0;
    logic rsp_valid;
    logic [1:0]  rsp_exc;
    logic [31:0] rsp_value, rsp_cookie;
    logic [79:0] dev_if_ids;
    logic [31:0] dev_fn_masks;
    logic [NDEV-1:0] dev_req_valid;
    logic [NDEV-1:0] rdy_q = '0;
    logic [1:0]  dev_req_kind;
    logic [2:0]  dev_req_fn;
    logic [11:0] dev_req_extra;
    logic [3:0]  dev_req_handle;
    logic [31:0] dev_req_data;
    logic [NDEV-1:0] rspv_q = '0;
    logic [127:0] dev_rsp_data;
    logic [31:0] rdat_q [NDEV];
    int cnt_q [NDEV];
    int hs_cnt [NDEV];
    logic [1:0]  last_kind [NDEV];
    logic [2:0]  last_fn [NDEV];
    logic [11:0] last_extra [NDEV];
    logic [3:0]  last_handle [NDEV];
    logic [31:0] last_data [NDEV];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Device 0 and 3 share an identifier; masks: sparse, full, single, full.
    assign dev_if_ids   = {20'h12345, 20'h00001, 20'h0ABCD, 20'h12345};
    assign dev_fn_masks = {8'hFF, 8'h80, 8'hFF, 8'h05};

    always #4 clk = ~clk;

    ovl_dispatch u_ovl_dispatch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_fn(req_fn), .req_rs1(req_rs1), .req_data(req_data),
        .req_asid(req_asid), .rsp_valid(rsp_valid), .rsp_exc(rsp_exc),
        .rsp_value(rsp_value), .rsp_cookie(rsp_cookie), .dev_if_ids(dev_if_ids),
        .dev_fn_masks(dev_fn_masks), .dev_req_valid(dev_req_valid),
        .dev_req_ready(rdy_q), .dev_req_kind(dev_req_kind), .dev_req_fn(dev_req_fn),
        .dev_req_extra(dev_req_extra), .dev_req_handle(dev_req_handle),
        .dev_req_data(dev_req_data), .dev_rsp_valid(rspv_q), .dev_rsp_data(dev_rsp_data)
    );

    function automatic logic [31:0] dev_fn(int dev, logic [1:0] kind, logic [2:0] fn,
                                           logic [11:0] extra, logic [31:0] data);
        return data + (32'(dev) << 24) + (32'(kind) << 20) + (32'(fn) << 16) + 32'(extra);
    endfunction

    for (genvar g = 0; g < NDEV; g++) begin : g_rd
        assign dev_rsp_data[g*32 +: 32] = rdat_q[g];
    end

    // Device models: ready one cycle late, answer two cycles after handshake.
    always @(posedge clk) begin
        for (int i = 0; i < NDEV; i++) begin
            rspv_q[i] <= 1'b0;
            if (!rst_n) begin
                rdy_q[i] <= 1'b0;
                cnt_q[i] <= 0;
                hs_cnt[i] <= 0;
                rdat_q[i] <= '0;
            end else begin
                rdy_q[i] <= dev_req_valid[i] & ~rdy_q[i];
                if (dev_req_valid[i] && rdy_q[i]) begin
                    hs_cnt[i]      <= hs_cnt[i] + 1;
                    last_kind[i]   <= dev_req_kind;
                    last_fn[i]     <= dev_req_fn;
                    last_extra[i]  <= dev_req_extra;
                    last_handle[i] <= dev_req_handle;
                    last_data[i]   <= dev_req_data;
                    rdat_q[i] <= dev_fn(i, dev_req_kind, dev_req_fn, dev_req_extra, dev_req_data);
                    cnt_q[i] <= 2;
                end else if (cnt_q[i] == 1) begin
                    rspv_q[i] <= 1'b1;
                    cnt_q[i]  <= 0;
                end else if (cnt_q[i] > 1) begin
                    cnt_q[i] <= cnt_q[i] - 1;
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    int tot_hs;
    function automatic int all_hs();
        int s = 0;
        for (int i = 0; i < NDEV; i++) s += hs_cnt[i];
        return s;
    endfunction

    logic [1:0]  r_exc;
    logic [31:0] r_val, r_cookie;
    int          r_lat;
    bit          r_busy;

    task automatic do_req(logic [1:0] op, logic [2:0] fn, logic [31:0] rs1,
                          logic [31:0] data, logic [7:0] asid);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_fn = fn;
        req_rs1 = rs1; req_data = data; req_asid = asid;
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 1; r_busy = 0;
        while (!rsp_valid && r_lat < 100) begin
            if (!req_ready) r_busy = 1;
            @(negedge clk);
            r_lat++;
        end
        r_exc = rsp_exc; r_val = rsp_value; r_cookie = rsp_cookie;
    endtask

    task automatic t_reset();
        chk("R10 req_ready", 32'(req_ready), 32'd1);
        chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R10 dev_req_valid", 32'(dev_req_valid), 32'd0);
        tot_hs = all_hs();
        do_req(CTL, 3'd0, 32'h0000_0000, 32'h1, 8'd0);
        chk("R10 table empty", 32'(r_exc), 32'(E_NIF));
    endtask

    task automatic t_open_unknown();
        tot_hs = all_hs();
        do_req(OPN, 3'd0, 32'h0005_5555, 32'h0, 8'd3);
        chk("R1 exc", 32'(r_exc), 32'(E_NIF));
        chk("R1 latency", 32'(r_lat), 32'd1);
        chk("R1 no forward", 32'(all_hs()), 32'(tot_hs));
    endtask

    task automatic t_open_ok();
        int h0;
        h0 = hs_cnt[0];
        do_req(OPN, 3'd0, 32'h0001_2345, 32'hA000_0000, 8'd3);
        chk("R2 exc", 32'(r_exc), 32'(E_OK));
        chk("R2 handle", r_val, 32'h0000_0000);
        chk("R2 cookie", r_cookie, dev_fn(0, 2'd0, 3'd0, 12'd0, 32'hA000_0000));
        chk("R2 lowest device", 32'(hs_cnt[0] - h0), 32'd1);
        chk("R2 dev3 idle", 32'(hs_cnt[3]), 32'd0);
        chk("R9 busy seen", 32'(r_busy), 32'd1);
        do_req(OPN, 3'd0, 32'h0000_ABCD, 32'hB000_0000, 8'd3);
        chk("R2 next slot", r_val, 32'h0000_1000);
        chk("R2 kind init", 32'(last_kind[1]), 32'd0);
    endtask

    task automatic t_ctl_ok();
        int h0;
        h0 = hs_cnt[0];
        do_req(CTL, 3'd2, 32'h0000_03A5, 32'h0000_7000, 8'd3);
        chk("R4 exc", 32'(r_exc), 32'(E_OK));
        chk("R4 value", r_val, dev_fn(0, 2'd1, 3'd2, 12'h3A5, 32'h0000_7000));
        chk("R4 extra", 32'(last_extra[0]), 32'h3A5);
        chk("R4 fn", 32'(last_fn[0]), 32'd2);
        chk("R4 handle", 32'(last_handle[0]), 32'd0);
        chk("R9 one handshake", 32'(hs_cnt[0] - h0), 32'd1);
    endtask

    task automatic t_mask();
        tot_hs = all_hs();
        do_req(CTL, 3'd1, 32'h0000_0000, 32'h1, 8'd3);
        chk("R7 mask clear", 32'(r_exc), 32'(E_NIN));
        do_req(2'd3, 3'd0, 32'h0000_0000, 32'h1, 8'd3);
        chk("R7 reserved op", 32'(r_exc), 32'(E_NIN));
        chk("R7 no forward", 32'(all_hs()), 32'(tot_hs));
    endtask

    task automatic t_bad_handle();
        logic [1:0] e_foreign, e_closed;
        logic [31:0] v_foreign, v_closed;
        tot_hs = all_hs();
        do_req(CTL, 3'd0, 32'h0000_0000, 32'h1, 8'd4);
        e_foreign = r_exc; v_foreign = r_val;
        do_req(CTL, 3'd0, 32'h0000_5000, 32'h1, 8'd3);
        e_closed = r_exc; v_closed = r_val;
        chk("R6 foreign exc", 32'(e_foreign), 32'(E_NIF));
        chk("R6 same as closed", {e_foreign, v_foreign[29:0]}, {e_closed, v_closed[29:0]});
        chk("R5 closed exc", 32'(e_closed), 32'(E_NIF));
        do_req(CTL, 3'd0, 32'h8000_0000, 32'h1, 8'd3);
        chk("R5 high bits", 32'(r_exc), 32'(E_NIF));
        chk("R5 no forward", 32'(all_hs()), 32'(tot_hs));
    endtask

    task automatic t_close();
        do_req(CLS, 3'd0, 32'h0000_1000, 32'h0, 8'd4);
        chk("R6 foreign close", 32'(r_exc), 32'(E_NIF));
        do_req(CLS, 3'd0, 32'h0000_1000, 32'h0000_0042, 8'd3);
        chk("R8 close exc", 32'(r_exc), 32'(E_OK));
        chk("R8 close value", r_val, dev_fn(1, 2'd2, 3'd0, 12'd0, 32'h0000_0042));
        do_req(CTL, 3'd0, 32'h0000_1000, 32'h0, 8'd3);
        chk("R8 freed", 32'(r_exc), 32'(E_NIF));
        do_req(OPN, 3'd0, 32'h0000_0001, 32'h0, 8'd3);
        chk("R8 reuse slot", r_val, 32'h0000_1000);
        do_req(CTL, 3'd7, 32'h0000_1000, 32'h5, 8'd3);
        chk("R7 single mask ok", r_val, dev_fn(2, 2'd1, 3'd7, 12'd0, 32'h5));
        do_req(CTL, 3'd0, 32'h0000_1000, 32'h5, 8'd3);
        chk("R7 single mask miss", 32'(r_exc), 32'(E_NIN));
    endtask

    task automatic t_full();
        for (int i = 2; i < 16; i++) begin
            do_req(OPN, 3'd0, 32'h0000_ABCD, 32'h0, 8'd5);
            chk("R3 fill slot", r_val, 32'(i) << 12);
        end
        do_req(OPN, 3'd0, 32'h0000_ABCD, 32'h0, 8'd5);
        chk("R3 exhausted", 32'(r_exc), 32'(E_EXH));
        do_req(OPN, 3'd0, 32'h000F_0F0F, 32'h0, 8'd5);
        chk("R3 unknown when full", 32'(r_exc), 32'(E_NIF));
        do_req(CLS, 3'd0, 32'h0000_F000, 32'h0, 8'd5);
        chk("R8 close last", 32'(r_exc), 32'(E_OK));
        do_req(OPN, 3'd0, 32'h0000_ABCD, 32'h0, 8'd5);
        chk("R3 reopen last", r_val, 32'h0000_F000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_open_unknown();
        t_open_ok();
        t_ctl_ok();
        t_mask();
        t_bad_handle();
        t_close();
        t_full();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule